// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block is the device-side command interpreter of a serial NOR flash. It samples the chip select, serial clock and serial input with a fast system clock, and finds the serial clock edges from those samples. From the first eight rising edges of a transaction it assembles the opcode. It then collects the address, dummy and data bytes that follow. Read-type commands stream bytes back on the falling edges of the serial clock. These bytes are the status byte, identification bytes, or array data fetched through a byte request/acknowledge port.

Write-type commands are checked when chip select rises. Each must end on a whole byte, must carry enough bytes, and, for program, erase and status write, needs the write-enable latch to be set. A command that passes these checks raises a one-cycle execute strobe with its command code, address and first data byte. Page program data bytes are passed downstream as they complete. Only the execute strobe commits them, so a program that ends on a partial byte is dropped as a whole.

Top module: `flash_cmd_fe`

## Requirements
- R1: The opcode is the first eight bits after chip select falls, taken most significant bit first on rising serial clock edges. Opcodes recognised: 0x06 set latch, 0x04 clear latch, 0x05 status read, 0x01 status write, 0x03 read, 0x0B fast read, 0x3B dual fast read, 0x02 page program, 0x20/0x52/0xD8 erases, 0xC7 and 0x60 chip erase, 0xB9 power-down, 0xAB release/device id, 0x90 manufacturer/device id, 0x9F identification.
- R2: Commands with an address take three address bytes, high byte first, and report them on exec_addr_o.
- R3: Status write, program, erase, power-down, set latch and clear latch take effect only if chip select rises after a whole number of bytes, and only with at least their minimum byte count: opcode plus 3 address bytes for erase, plus 1 data byte for program, 2 bytes for status write. Otherwise they leave no trace.
- R4: The write-enable latch is reported in bit 1 of the status byte. Bits 7:2 come from status_hi_i and bit 0 from busy_i. The latch is set by 0x06 and cleared by 0x04 and by any accepted program, erase or status write.
- R5: Program, erase and status write are discarded while the latch is clear.
- R6: Each complete page program data byte is pulsed on pg_wr_o and pg_data_o. If the final byte is partial, no execute strobe follows and the latch stays set.
- R7: Status read streams the status byte on sd_o[1], repeated for as long as clocks continue, with each bit driven on a falling edge.
- R8: Read 0x03 outputs array data right after the third address byte, moving to the next address after each byte.
- R9: Fast read 0x0B skips one dummy byte before the data.
- R10: Dual fast read 0x3B drives two bits per falling edge: sd_o[1] carries bits 7,5,3,1 and sd_o[0] carries bits 6,4,2,0. Both lines are enabled.
- R11: 0x9F returns the manufacturer id, then the high and low identification bytes, cycling. 0x90 returns manufacturer id and device id in turn after three bytes. 0xAB returns the device id after three dummy bytes and raises an execute strobe at deselect.
- R12: Raising chip select ends any read at any bit, turns the outputs off and restarts opcode capture for the next transaction.
- R13: An unknown opcode causes the rest of the transaction to be ignored: no output enable and no execute strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock, sampled on clk_i |
| si_i | input | 1 | Serial data in |
| sd_o | output | 2 | Serial data out (bit 1 single line, both in dual mode) |
| sd_oe_o | output | 2 | Output enables for sd_o |
| status_hi_i | input | 6 | Status bits 7:2 |
| busy_i | input | 1 | Status bit 0 |
| rd_req_o | output | 1 | Array byte request pulse |
| rd_addr_o | output | 24 | Array byte address |
| rd_ack_i | input | 1 | Array byte response valid |
| rd_data_i | input | 8 | Array byte response |
| pg_wr_o | output | 1 | Program data byte pulse |
| pg_data_o | output | 8 | Program data byte |
| exec_o | output | 1 | Execute strobe, one cycle |
| exec_cmd_o | output | 5 | Command code of the executed command |
| exec_addr_o | output | 24 | Address of the executed command |
| exec_data_o | output | 8 | First data byte (status write) |

## Verification
The assertions take for granted that chip select, serial clock and serial input are already synchronous to clk_i. They also assume that each serial clock phase lasts several system clocks, that chip select stays high for a few cycles after a deselect, and that the array answers a request within two cycles. The bench meets all of this by driving every input on the falling system clock edge, holding each serial clock phase for six system clocks and chip select high for eighteen, and answering requests with a one-cycle registered memory model.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;
  localparam int CMD_W = 5;
  typedef enum logic [CMD_W-1:0] {
    CMD_NONE, CMD_WREN, CMD_WRDI, CMD_RDSR, CMD_WRSR, CMD_READ, CMD_FAST,
    CMD_DUAL, CMD_PP, CMD_SE, CMD_BE32, CMD_BE64, CMD_CE, CMD_DPD,
    CMD_RES, CMD_REMS, CMD_RDID
  } cmd_e;
endpackage

// File: rtl/fe_shift_in.sv
module fe_shift_in #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             sclk_i,
  input  logic             si_i,
  output logic             fall_o,
  output logic             desel_o,
  output logic             byte_vld_o,
  output logic [7:0]       byte_o,
  output logic [CNT_W-1:0] byte_idx_o,
  output logic [2:0]       bit_cnt_o,
  output logic [CNT_W-1:0] byte_cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic       sclk_q, cs_q, rise;
  logic [6:0] sh_q;

  assign rise    = sclk_i & ~sclk_q & ~cs_ni;
  assign fall_o  = ~sclk_i & sclk_q & ~cs_ni;
  assign desel_o = cs_ni & ~cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_i;
      cs_q   <= cs_ni;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q       <= '0;
      bit_cnt_o  <= '0;
      byte_cnt_o <= '0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
      byte_idx_o <= '0;
    end else if (cs_ni) begin
      bit_cnt_o  <= '0;
      byte_cnt_o <= '0;
      byte_vld_o <= 1'b0;
    end else begin
      byte_vld_o <= 1'b0;
      if (rise) begin
        sh_q      <= {sh_q[5:0], si_i};
        bit_cnt_o <= bit_cnt_o + 3'd1;
        if (bit_cnt_o == 3'd7) begin
          byte_vld_o <= 1'b1;
          byte_o     <= {sh_q, si_i};
          byte_idx_o <= byte_cnt_o;
          if (byte_cnt_o != CNT_MAX) byte_cnt_o <= byte_cnt_o + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fe_decode.sv
module fe_decode
  import flash_fe_pkg::*;
#(
  parameter int ADDR_BYTES = 3
) (
  input  logic [7:0] op_i,
  output cmd_e       cmd_o,
  output logic       need_wel_o,
  output logic       need_bnd_o,
  output logic       has_addr_o,
  output logic [3:0] min_bytes_o,
  output logic [3:0] out_at_o
);
  localparam logic [3:0] A1 = 4'(ADDR_BYTES + 1);
  localparam logic [3:0] A2 = 4'(ADDR_BYTES + 2);

  always_comb begin
    cmd_o       = CMD_NONE;
    need_wel_o  = 1'b0;
    need_bnd_o  = 1'b0;
    has_addr_o  = 1'b0;
    min_bytes_o = 4'd1;
    out_at_o    = 4'd0;
    unique case (op_i)
      8'h06: begin cmd_o = CMD_WREN; need_bnd_o = 1'b1; end
      8'h04: begin cmd_o = CMD_WRDI; need_bnd_o = 1'b1; end
      8'h05: begin cmd_o = CMD_RDSR; out_at_o = 4'd1; end
      8'h01: begin
        cmd_o = CMD_WRSR; need_wel_o = 1'b1; need_bnd_o = 1'b1; min_bytes_o = 4'd2;
      end
      8'h03: begin cmd_o = CMD_READ; has_addr_o = 1'b1; out_at_o = A1; end
      8'h0B: begin cmd_o = CMD_FAST; has_addr_o = 1'b1; out_at_o = A2; end
      8'h3B: begin cmd_o = CMD_DUAL; has_addr_o = 1'b1; out_at_o = A2; end
      8'h02: begin
        cmd_o = CMD_PP; has_addr_o = 1'b1; need_wel_o = 1'b1; need_bnd_o = 1'b1;
        min_bytes_o = A2;
      end
      8'h20, 8'h52, 8'hD8: begin
        cmd_o = (op_i == 8'h20) ? CMD_SE : (op_i == 8'h52) ? CMD_BE32 : CMD_BE64;
        has_addr_o = 1'b1; need_wel_o = 1'b1; need_bnd_o = 1'b1; min_bytes_o = A1;
      end
      8'hC7, 8'h60: begin cmd_o = CMD_CE; need_wel_o = 1'b1; need_bnd_o = 1'b1; end
      8'hB9: begin cmd_o = CMD_DPD; need_bnd_o = 1'b1; end
      8'hAB: begin cmd_o = CMD_RES; out_at_o = A1; end
      8'h90: begin cmd_o = CMD_REMS; has_addr_o = 1'b1; out_at_o = A1; end
      8'h9F: begin cmd_o = CMD_RDID; out_at_o = 4'd1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/fe_shift_out.sv
module fe_shift_out (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       fall_i,
  input  logic       start_i,
  input  logic       dual_i,
  input  logic [7:0] byte_i,
  output logic       load_o,
  output logic [1:0] sd_o,
  output logic [1:0] oe_o
);
  logic       en_q;
  logic [2:0] rem_q;
  logic [7:0] sh_q;

  assign load_o = fall_i & en_q & (rem_q == 3'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0; rem_q <= '0; sh_q <= '0; sd_o <= '0; oe_o <= '0;
    end else if (cs_ni) begin
      en_q <= 1'b0; rem_q <= '0; sd_o <= '0; oe_o <= '0;
    end else begin
      if (start_i) en_q <= 1'b1;
      if (fall_i && en_q) begin
        oe_o <= dual_i ? 2'b11 : 2'b10;
        if (rem_q == 3'd0) begin
          if (dual_i) begin
            sd_o <= byte_i[7:6]; sh_q <= {byte_i[5:0], 2'b00}; rem_q <= 3'd3;
          end else begin
            sd_o <= {byte_i[7], 1'b0}; sh_q <= {byte_i[6:0], 1'b0}; rem_q <= 3'd7;
          end
        end else begin
          rem_q <= rem_q - 3'd1;
          if (dual_i) begin
            sd_o <= sh_q[7:6]; sh_q <= {sh_q[5:0], 2'b00};
          end else begin
            sd_o <= {sh_q[7], 1'b0}; sh_q <= {sh_q[6:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/flash_cmd_fe.sv
module flash_cmd_fe
  import flash_fe_pkg::*;
#(
  parameter int          ADDR_BYTES = 3,
  parameter int          CNT_W      = 4,
  parameter logic [7:0]  MFR_ID     = 8'hC8,
  parameter logic [7:0]  DEV_ID     = 8'h10,
  parameter logic [15:0] JEDEC_ID   = 16'h4011,
  localparam int         ADDR_W     = 8 * ADDR_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              si_i,
  output logic [1:0]        sd_o,
  output logic [1:0]        sd_oe_o,
  input  logic [5:0]        status_hi_i,
  input  logic              busy_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [7:0]        rd_data_i,
  output logic              pg_wr_o,
  output logic [7:0]        pg_data_o,
  output logic              exec_o,
  output logic [CMD_W-1:0]  exec_cmd_o,
  output logic [ADDR_W-1:0] exec_addr_o,
  output logic [7:0]        exec_data_o
);
  logic             fall, desel, byte_vld;
  logic [7:0]       byte_w;
  logic [CNT_W-1:0] byte_idx, byte_cnt;
  logic [2:0]       bit_cnt;

  fe_shift_in #(.CNT_W(CNT_W)) u_in (
    .clk_i, .rst_ni, .cs_ni, .sclk_i, .si_i,
    .fall_o(fall), .desel_o(desel), .byte_vld_o(byte_vld), .byte_o(byte_w),
    .byte_idx_o(byte_idx), .bit_cnt_o(bit_cnt), .byte_cnt_o(byte_cnt)
  );

  logic [7:0]        op_q, dat_q, rdbuf_q, pg_data_q, dec_op, out_byte;
  logic              op_vld_q, wel_q, rd_req_q, pg_wr_q, exec_q;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        seq_q;
  cmd_e              dec_cmd, cmd_eff, exec_cmd_q;
  logic              dec_wel, dec_bnd, dec_addr, is_rd, out_start, load, accept, exec_go;
  logic [3:0]        dec_min, dec_out_at;

  // decode the byte in flight while the opcode lands, the stored opcode afterwards
  assign dec_op = (byte_vld && byte_idx == '0) ? byte_w : op_q;

  fe_decode #(.ADDR_BYTES(ADDR_BYTES)) u_dec (
    .op_i(dec_op), .cmd_o(dec_cmd), .need_wel_o(dec_wel), .need_bnd_o(dec_bnd),
    .has_addr_o(dec_addr), .min_bytes_o(dec_min), .out_at_o(dec_out_at)
  );

  assign cmd_eff   = op_vld_q ? dec_cmd : CMD_NONE;
  assign is_rd     = cmd_eff inside {CMD_READ, CMD_FAST, CMD_DUAL};
  assign out_start = byte_vld && (dec_out_at != 4'd0) &&
                     (int'(byte_idx) == int'(dec_out_at) - 1);
  assign accept    = desel && op_vld_q && dec_bnd && (bit_cnt == 3'd0) &&
                     (int'(byte_cnt) >= int'(dec_min)) && (!dec_wel || wel_q);
  assign exec_go   = (accept && (cmd_eff inside {CMD_WRSR, CMD_PP, CMD_SE, CMD_BE32,
                                                CMD_BE64, CMD_CE, CMD_DPD})) ||
                     (desel && cmd_eff == CMD_RES);

  always_comb begin
    unique case (cmd_eff)
      CMD_RDSR:                     out_byte = {status_hi_i, wel_q, busy_i};
      CMD_READ, CMD_FAST, CMD_DUAL: out_byte = rdbuf_q;
      CMD_RDID: out_byte = (seq_q == 2'd0) ? MFR_ID :
                           (seq_q == 2'd1) ? JEDEC_ID[15:8] : JEDEC_ID[7:0];
      CMD_REMS:                     out_byte = seq_q[0] ? DEV_ID : MFR_ID;
      CMD_RES:                      out_byte = DEV_ID;
      default:                      out_byte = 8'h00;
    endcase
  end

  fe_shift_out u_out (
    .clk_i, .rst_ni, .cs_ni, .fall_i(fall), .start_i(out_start),
    .dual_i(cmd_eff == CMD_DUAL), .byte_i(out_byte), .load_o(load),
    .sd_o, .oe_o(sd_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q <= '0; op_vld_q <= 1'b0; dat_q <= '0; rdbuf_q <= '0; addr_q <= '0;
      seq_q <= '0; wel_q <= 1'b0; rd_req_q <= 1'b0; pg_wr_q <= 1'b0;
      pg_data_q <= '0; exec_q <= 1'b0; exec_cmd_q <= CMD_NONE;
    end else begin
      rd_req_q <= 1'b0;
      pg_wr_q  <= 1'b0;
      exec_q   <= 1'b0;
      if (rd_ack_i) begin
        rdbuf_q <= rd_data_i;
        addr_q  <= addr_q + ADDR_W'(1);
      end
      if (exec_go) begin
        exec_q     <= 1'b1;
        exec_cmd_q <= cmd_eff;
      end
      if (accept) begin
        if (cmd_eff == CMD_WREN) wel_q <= 1'b1;
        else if (cmd_eff == CMD_WRDI || dec_wel) wel_q <= 1'b0;
      end
      if (cs_ni) begin
        op_vld_q <= 1'b0;
        seq_q    <= '0;
      end else begin
        if (byte_vld) begin
          if (byte_idx == '0) begin
            op_q     <= byte_w;
            op_vld_q <= 1'b1;
          end else begin
            if (dec_addr && int'(byte_idx) <= ADDR_BYTES) begin
              addr_q <= ADDR_W'({addr_q, byte_w});
              if (int'(byte_idx) == ADDR_BYTES && is_rd) rd_req_q <= 1'b1;
            end
            if (cmd_eff == CMD_WRSR && int'(byte_idx) == 1) dat_q <= byte_w;
            if (cmd_eff == CMD_PP && int'(byte_idx) > ADDR_BYTES) begin
              pg_wr_q   <= 1'b1;
              pg_data_q <= byte_w;
            end
          end
        end
        if (load) begin
          seq_q <= (cmd_eff == CMD_RDID && seq_q == 2'd2) ? 2'd0 : seq_q + 2'd1;
          if (is_rd) rd_req_q <= 1'b1;  // prefetch the byte after the one just loaded
        end
      end
    end
  end

  assign rd_req_o    = rd_req_q;
  assign rd_addr_o   = addr_q;
  assign pg_wr_o     = pg_wr_q;
  assign pg_data_o   = pg_data_q;
  assign exec_o      = exec_q;
  assign exec_cmd_o  = exec_cmd_q;
  assign exec_addr_o = addr_q;
  assign exec_data_o = dat_q;
endmodule

// File: rtl/flash_cmd_fe_chk.sv
module flash_cmd_fe_chk
  import flash_fe_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_ni,
  input logic [1:0]       sd_oe_o,
  input logic             exec_o,
  input logic [CMD_W-1:0] exec_cmd_o,
  input logic             wel_q,
  input logic             pg_wr_o,
  input logic [CMD_W-1:0] cmd_cur
);
  // R12: outputs released once deselected
  a_r12_idle_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni)) |-> (sd_oe_o == 2'b00));

  // R10: line 0 never enabled without line 1
  a_r10_oe_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sd_oe_o != 2'b01);

  // R4, R5: a gated command consumes a set latch
  a_r4_wel_consumed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_o && (exec_cmd_o inside {CMD_PP, CMD_SE, CMD_BE32, CMD_BE64, CMD_CE, CMD_WRSR}))
    |-> (!wel_q && $past(wel_q)));

  // R3: execution only follows deselect
  a_r3_exec_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o |-> cs_ni);

  // R6: program data only inside a page program
  a_r6_pg_only_pp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pg_wr_o |-> (cmd_cur == CMD_PP));

  // R13: no output without a recognised command
  a_r13_unknown_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_cur == CMD_NONE) |-> (sd_oe_o == 2'b00));
endmodule

bind flash_cmd_fe flash_cmd_fe_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .sd_oe_o(sd_oe_o),
  .exec_o(exec_o), .exec_cmd_o(exec_cmd_o), .wel_q(wel_q), .pg_wr_o(pg_wr_o),
  .cmd_cur(cmd_eff)
);

// File: tb/tb_flash_cmd_fe.sv
module tb_flash_cmd_fe;
  import flash_fe_pkg::*;

  localparam int          CLK_P = 10;
  localparam int          HALF  = 6;
  localparam logic [7:0]  MFR   = 8'h5E;
  localparam logic [7:0]  DEV   = 8'h21;
  localparam logic [15:0] JID   = 16'h7A3C;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, si = 1'b0;
  logic [5:0]  st_hi = 6'b101001;
  logic        busy = 1'b0;
  logic        rd_ack = 1'b0;
  logic [7:0]  rd_data = '0;
  logic [1:0]  sd, sd_oe;
  logic        rd_req, pg_wr, exec;
  logic [23:0] rd_addr, exec_addr;
  logic [7:0]  pg_data, exec_data;
  logic [CMD_W-1:0] exec_cmd;

  flash_cmd_fe #(.MFR_ID(MFR), .DEV_ID(DEV), .JEDEC_ID(JID)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .si_i(si),
    .sd_o(sd), .sd_oe_o(sd_oe), .status_hi_i(st_hi), .busy_i(busy),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_ack_i(rd_ack), .rd_data_i(rd_data),
    .pg_wr_o(pg_wr), .pg_data_o(pg_data), .exec_o(exec), .exec_cmd_o(exec_cmd),
    .exec_addr_o(exec_addr), .exec_data_o(exec_data)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] mem_f(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    rd_ack  <= rd_req;
    rd_data <= mem_f(rd_addr);
  end

  int ex_cnt = 0, pg_cnt = 0;
  logic [CMD_W-1:0] ex_cmd;
  logic [23:0] ex_addr;
  logic [7:0]  ex_data, pg_last;
  always @(posedge clk) begin
    if (exec) begin ex_cnt++; ex_cmd = exec_cmd; ex_addr = exec_addr; ex_data = exec_data; end
    if (pg_wr) begin pg_cnt++; pg_last = pg_data; end
  end

  int checks = 0, errors = 0;
  logic oe_seen;
  localparam logic [7:0] ST0 = {6'b101001, 1'b0, 1'b0};
  localparam logic [7:0] ST1 = {6'b101001, 1'b1, 1'b0};

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sel();
    @(negedge clk) cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic desel();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (3*HALF) @(negedge clk);
  endtask

  task automatic bit_io(input logic b, output logic [1:0] o);
    si = b;
    repeat (HALF) @(negedge clk);
    o = sd;
    oe_seen = oe_seen | (|sd_oe);
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic byte_io(input logic [7:0] tx, output logic [7:0] rx);
    logic [1:0] o;
    for (int i = 7; i >= 0; i--) begin bit_io(tx[i], o); rx[i] = o[1]; end
  endtask

  task automatic dual_rx(output logic [7:0] rx);
    logic [1:0] o;
    for (int i = 3; i >= 0; i--) begin bit_io(1'b0, o); rx[2*i+1] = o[1]; rx[2*i] = o[0]; end
  endtask

  task automatic send(input logic [7:0] b);
    logic [7:0] d;
    byte_io(b, d);
  endtask

  task automatic send_addr(input logic [23:0] a);
    send(a[23:16]); send(a[15:8]); send(a[7:0]);
  endtask

  task automatic cmd1(input logic [7:0] op);
    sel(); send(op); desel();
  endtask

  task automatic rdsr(output logic [7:0] s);
    sel(); send(8'h05); byte_io(8'h00, s); desel();
  endtask

  task automatic t_reset();
    logic [7:0] s;
    chk(sd_oe == 2'b00 && ex_cnt == 0, "R12 reset outputs", {sd_oe, ex_cnt[7:0]}, 0);
    rdsr(s);
    chk(s == ST0, "R4 reset latch clear", s, ST0);
  endtask

  task automatic t_latch();
    logic [7:0] s, s2;
    cmd1(8'h06); rdsr(s);
    chk(s == ST1, "R4 R1 set latch", s, ST1);
    sel(); send(8'h05); byte_io(8'h00, s); byte_io(8'h00, s2); desel();
    chk(s2 == ST1, "R7 status streams", s2, ST1);
    cmd1(8'h04); rdsr(s);
    chk(s == ST0, "R4 clear latch", s, ST0);
  endtask

  task automatic t_erase();
    int n;
    logic [7:0] s;
    logic [1:0] o;
    cmd1(8'h06);
    n = ex_cnt;
    sel(); send(8'h20); send_addr(24'h123456); desel();
    chk(ex_cnt == n + 1 && ex_cmd == CMD_SE, "R3 erase accepted", ex_cmd, CMD_SE);
    chk(ex_addr == 24'h123456, "R2 address high byte first", ex_addr, 24'h123456);
    rdsr(s);
    chk(s == ST0, "R4 erase clears latch", s, ST0);
    cmd1(8'h06);
    n = ex_cnt;
    sel(); send(8'hD8); send_addr(24'h0ABCDE); bit_io(1'b1, o); bit_io(1'b0, o); bit_io(1'b1, o); desel();
    chk(ex_cnt == n, "R3 partial byte rejected", ex_cnt, n);
    sel(); send(8'h52); send(8'h12); send(8'h34); desel();
    chk(ex_cnt == n, "R3 short erase rejected", ex_cnt, n);
    rdsr(s);
    chk(s == ST1, "R3 latch kept after reject", s, ST1);
    cmd1(8'h04);
  endtask

  task automatic t_gate();
    int n;
    n = ex_cnt;
    cmd1(8'hC7);
    chk(ex_cnt == n, "R5 erase without latch", ex_cnt, n);
    cmd1(8'h06); cmd1(8'h60);
    chk(ex_cnt == n + 1 && ex_cmd == CMD_CE, "R1 chip erase alias", ex_cmd, CMD_CE);
    cmd1(8'hB9);
    chk(ex_cnt == n + 2 && ex_cmd == CMD_DPD, "R3 power-down", ex_cmd, CMD_DPD);
  endtask

  task automatic t_program();
    int n, p;
    logic [7:0] s;
    logic [1:0] o;
    cmd1(8'h06);
    n = ex_cnt; p = pg_cnt;
    sel(); send(8'h02); send_addr(24'h000100); send(8'hAA); send(8'h55); desel();
    chk(pg_cnt == p + 2 && pg_last == 8'h55, "R6 data bytes", pg_last, 8'h55);
    chk(ex_cnt == n + 1 && ex_cmd == CMD_PP, "R6 program commit", ex_cmd, CMD_PP);
    cmd1(8'h06);
    n = ex_cnt; p = pg_cnt;
    sel(); send(8'h02); send_addr(24'h000200); send(8'h11);
    for (int i = 0; i < 5; i++) bit_io(1'b1, o);
    desel();
    chk(pg_cnt == p + 1 && ex_cnt == n, "R6 partial program dropped", ex_cnt, n);
    rdsr(s);
    chk(s == ST1, "R6 latch kept", s, ST1);
    n = ex_cnt;
    sel(); send(8'h01); send(8'h3C); desel();
    chk(ex_cnt == n + 1 && ex_cmd == CMD_WRSR && ex_data == 8'h3C, "R4 status write", ex_data, 8'h3C);
  endtask

  task automatic t_read();
    logic [7:0] r, s;
    logic [1:0] o;
    sel(); send(8'h03); send_addr(24'h001020);
    for (int i = 0; i < 3; i++) begin
      byte_io(8'h00, r);
      chk(r == mem_f(24'h001020 + 24'(i)), "R8 read stream", r, mem_f(24'h001020 + 24'(i)));
    end
    bit_io(1'b0, o); bit_io(1'b0, o);
    desel();
    chk(sd_oe == 2'b00, "R12 read ended mid byte", sd_oe, 0);
    rdsr(s);
    chk(s == ST0, "R12 fresh opcode after abort", s, ST0);
    sel(); send(8'h0B); send_addr(24'h00FF07); send(8'h00);
    for (int i = 0; i < 2; i++) begin
      byte_io(8'h00, r);
      chk(r == mem_f(24'h00FF07 + 24'(i)), "R9 fast read", r, mem_f(24'h00FF07 + 24'(i)));
    end
    desel();
    sel(); send(8'h3B); send_addr(24'h003300); send(8'h00);
    for (int i = 0; i < 2; i++) begin
      dual_rx(r);
      chk(r == mem_f(24'h003300 + 24'(i)), "R10 dual read", r, mem_f(24'h003300 + 24'(i)));
    end
    chk(sd_oe == 2'b11, "R10 both lines enabled", sd_oe, 2'b11);
    desel();
  endtask

  task automatic t_ids();
    logic [7:0] r;
    int n;
    logic [7:0] exp9f [4];
    exp9f[0] = MFR; exp9f[1] = JID[15:8]; exp9f[2] = JID[7:0]; exp9f[3] = MFR;
    sel(); send(8'h9F);
    for (int i = 0; i < 4; i++) begin
      byte_io(8'h00, r);
      chk(r == exp9f[i], "R11 identification", r, exp9f[i]);
    end
    desel();
    sel(); send(8'h90); send_addr(24'h0);
    byte_io(8'h00, r); chk(r == MFR, "R11 maker id", r, MFR);
    byte_io(8'h00, r); chk(r == DEV, "R11 device id", r, DEV);
    desel();
    n = ex_cnt;
    sel(); send(8'hAB); send_addr(24'h0);
    byte_io(8'h00, r); chk(r == DEV, "R11 release id", r, DEV);
    byte_io(8'h00, r); chk(r == DEV, "R11 release id repeat", r, DEV);
    desel();
    chk(ex_cnt == n + 1 && ex_cmd == CMD_RES, "R11 release strobe", ex_cmd, CMD_RES);
  endtask

  task automatic t_unknown();
    int n;
    logic [7:0] r;
    n = ex_cnt;
    oe_seen = 1'b0;
    sel(); send(8'hFF); send(8'h05); byte_io(8'h00, r); byte_io(8'h00, r); desel();
    chk(!oe_seen, "R13 no output", oe_seen, 0);
    chk(ex_cnt == n, "R13 no strobe", ex_cnt, n);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    oe_seen = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_latch();
    t_erase();
    t_gate();
    t_program();
    t_read();
    t_ids();
    t_unknown();
    finish_run();
  end
endmodule